// File: doc/BRIEF.md
# Parallel NOR Flash Bus Front End

This block sits behind the pins of a 16-bit parallel NOR flash memory and turns the chip-enable, output-enable, write-enable and reset pins into one bus mode per clock. The modes are reset, standby, deferred standby, read, output disable, write, identifier read and protect-status read. It drives the data bus from the array word, from the identifier codes or from the per-sector protect map. Otherwise it holds the bus at high impedance. High-impedance is shown by `dq_oe` low.

For a write, it keeps the address from the first sampled cycle in which both enables are low. It keeps the data from the last such cycle. When the write ends, it sends both to the command register as a one-cycle strobe. Two digital flags mark the A9 pin and the reset pin at their high-voltage level. The A9 flag opens the identifier and protect-status responses. The reset flag lifts sector protection for as long as it is held.

All pins are sampled on `clk`, and every bus output is registered. A pin pattern seen at one rising edge therefore shows at the outputs right after that edge.

The state machine has the states S_RST, S_STBY, S_STBY_PEND, S_READ, S_ODIS, S_WRITE, S_IDRD and S_PSRD. Every sampled mode moves it to the matching state, with one exception. A standby request while `algo_busy` is high moves it to S_STBY_PEND, unless it is already in S_STBY. It stays in S_STBY_PEND until the busy flag drops. A move out of S_WRITE to any state except S_RST fires the command strobe. A move into S_RST clears the latches.

Top module: `nor_bus_front`

## Requirements
- R1: With ce_n=0, oe_n=0 and we_n=1, and the identifier decode not selected, dq_oe=1 and dq_out equals the array_word sampled at the same edge.
- R2: With ce_n=1 and algo_busy=0, dq_oe=0 and pwr_down=1 after that edge.
- R3: With ce_n=1 while algo_busy=1, dq_oe=0 and pwr_down stays 0. pwr_down rises right after the first edge that samples algo_busy=0.
- R4: With ce_n=0, oe_n=1 and we_n=1, or with oe_n=0 and we_n=0 together, dq_oe=0, pwr_down=0 and no command strobe results.
- R5: The write condition is ce_n=0, we_n=0 and oe_n=1. The command address is the addr sampled in the first cycle the condition holds, which is the later of the two falling enables.
- R6: The command data is the dq_in sampled in the last cycle the write condition holds, before the earlier of the two enables rises. After the first cycle without the condition, cmd_valid is 1 for exactly one cycle with cmd_addr and cmd_data.
- R7: With a9_hv=1, ce_n=0, oe_n=0, we_n=1, addr[6]=0 and addr[1]=0, dq_out is 16'h0052 when addr[0]=0 and is DEV_CODE (default 16'h2A70) when addr[0]=1. With addr[6]=1 an ordinary array read takes place.
- R8: With a9_hv=1, ce_n=0, oe_n=0, we_n=1, addr[6]=0 and addr[1]=1, dq_out is {15'b0, lock bit of sector addr[17:12]} when addr[0]=0, and 0 when addr[0]=1.
- R9: prot_wr=1 loads prot_wdata into the protect map. Bit i is sector i, and the map shows on sector_locked after that edge.
- R10: While rst_hv=1, sector_locked is all zero and protect-status reads return 0. When rst_hv returns to 0, the stored map is seen again without a reload.
- R11: rst_pin_n=0 with rst_hv=0 gives dq_oe=0, cmd_valid=0, cmd_addr=0 and cmd_data=0 after that edge. A write cut off this way never strobes.
- R12: While rst_n=0, dq_oe=0, cmd_valid=0, pwr_down=0 and sector_locked=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Block reset, active low |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| rst_pin_n | input | 1 | Device reset pin, active low |
| rst_hv | input | 1 | Reset pin at high voltage (temporary unlock) |
| a9_hv | input | 1 | A9 pin at high voltage (identifier access) |
| addr | input | 18 | Word address pins |
| dq_in | input | 16 | Data bus as driven by the host |
| dq_out | output | 16 | Data bus value driven by the device |
| dq_oe | output | 1 | Data bus drive enable; 0 means high impedance |
| array_word | input | 16 | Array word for the current address |
| algo_busy | input | 1 | Internal program or erase algorithm running |
| prot_wr | input | 1 | Protect map load strobe |
| prot_wdata | input | 64 | New protect map, one bit per sector |
| sector_locked | output | 64 | Effective protection per sector |
| pwr_down | output | 1 | Standby entered |
| cmd_valid | output | 1 | One-cycle command write strobe |
| cmd_addr | output | 18 | Latched command address |
| cmd_data | output | 16 | Latched command data |

## Verification
The end of a write and the start of the next mode fall in the same cycle. The command strobe then leaves in the same cycle as the new mode's bus drive, or the reset pin falls at that moment and must suppress the strobe. The random phase draws the pins afresh on every cycle, so writes often end straight into a read, an identifier read or a reset. A bench model follows the later-falling and earlier-rising edges and judges the strobe and the drive in that cycle separately. Directed sequences take the write enable leading and then the chip enable leading, and they cut a write off with the reset pin.

// File: rtl/nbf_pkg.sv
package nbf_pkg;

    typedef enum logic [2:0] {
        BM_RESET,
        BM_STANDBY,
        BM_READ,
        BM_OUTDIS,
        BM_WRITE,
        BM_IDENT,
        BM_PSTAT
    } bus_mode_e;

    typedef enum logic [2:0] {
        S_RST,
        S_STBY,
        S_STBY_PEND,
        S_READ,
        S_ODIS,
        S_WRITE,
        S_IDRD,
        S_PSRD
    } fe_state_e;

    localparam logic [7:0] MFR_ID = 8'h52;

endpackage

// File: rtl/nbf_mode_decode.sv
module nbf_mode_decode
    import nbf_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      we_n,
    input  logic      rst_pin_n,
    input  logic      rst_hv,
    input  logic      a9_hv,
    input  logic      addr6,
    input  logic      addr1,
    output bus_mode_e mode
);

    // Priority: pin reset, chip deselect, read family, write, no drive.
    always_comb begin
        if (!rst_pin_n && !rst_hv) begin
            mode = BM_RESET;
        end else if (ce_n) begin
            mode = BM_STANDBY;
        end else if (!oe_n && we_n) begin
            if (a9_hv && !addr6) begin
                mode = addr1 ? BM_PSTAT : BM_IDENT;
            end else begin
                mode = BM_READ;
            end
        end else if (oe_n && !we_n) begin
            mode = BM_WRITE;
        end else begin
            mode = BM_OUTDIS;
        end
    end

endmodule

// File: rtl/nbf_protect_map.sv
module nbf_protect_map #(
    parameter int SEC_W = 6,
    localparam int NSEC = 1 << SEC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_wr,
    input  logic [NSEC-1:0]  prot_wdata,
    input  logic             rst_hv,
    input  logic [SEC_W-1:0] sec_idx,
    output logic [NSEC-1:0]  sector_locked,
    output logic             sel_locked
);

    logic [NSEC-1:0] map_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
        end else if (prot_wr) begin
            map_q <= prot_wdata;
        end
    end

    // High voltage on the reset pin lifts every lock; the stored map survives.
    for (genvar g = 0; g < NSEC; g++) begin : g_sec
        assign sector_locked[g] = map_q[g] & ~rst_hv;
    end

    assign sel_locked = sector_locked[sec_idx];

    // R9
    map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(prot_wr) && !rst_hv && !$past(rst_hv)) |-> $stable(sector_locked));

endmodule

// File: rtl/nbf_write_latch.sv
module nbf_write_latch #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_enter,
    input  logic              wr_hold,
    input  logic              wr_leave,
    input  logic              wr_clear,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);

    logic [ADDR_W-1:0] addr_lat;
    logic [DATA_W-1:0] data_lat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_lat  <= '0;
            data_lat  <= '0;
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else if (wr_clear) begin
            addr_lat  <= '0;
            data_lat  <= '0;
            cmd_valid <= 1'b0;
            cmd_addr  <= '0;
            cmd_data  <= '0;
        end else begin
            cmd_valid <= wr_leave;
            if (wr_enter) begin
                addr_lat <= addr;
            end
            if (wr_hold) begin
                data_lat <= dq_in;
            end
            if (wr_leave) begin
                cmd_addr <= addr_lat;
                cmd_data <= data_lat;
            end
        end
    end

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R5
    write_precedes_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(wr_hold, 2));

endmodule

// File: rtl/nbf_bus_fsm.sv
module nbf_bus_fsm
    import nbf_pkg::*;
#(
    parameter int                DATA_W   = 16,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h2A70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_mode_e         mode,
    input  logic              algo_busy,
    input  logic              word_lsb,
    input  logic              pstat_bit,
    input  logic [DATA_W-1:0] array_word,
    output logic              wr_enter,
    output logic              wr_hold,
    output logic              wr_leave,
    output logic              wr_clear,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              pwr_down
);

    fe_state_e state_q;
    fe_state_e state_d;

    // Next state from the sampled bus mode.
    always_comb begin
        state_d = state_q;
        unique case (mode)
            BM_RESET:   state_d = S_RST;
            BM_STANDBY: begin
                if (state_q == S_STBY || !algo_busy) begin
                    state_d = S_STBY;
                end else begin
                    state_d = S_STBY_PEND;
                end
            end
            BM_READ:    state_d = S_READ;
            BM_OUTDIS:  state_d = S_ODIS;
            BM_WRITE:   state_d = S_WRITE;
            BM_IDENT:   state_d = S_IDRD;
            BM_PSTAT:   state_d = S_PSRD;
            default:    state_d = S_ODIS;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RST;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered bus outputs, taken from the state being entered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_oe  <= 1'b0;
            dq_out <= '0;
        end else begin
            unique case (state_d)
                S_READ: begin
                    dq_oe  <= 1'b1;
                    dq_out <= array_word;
                end
                S_IDRD: begin
                    dq_oe  <= 1'b1;
                    dq_out <= word_lsb ? DEV_CODE : DATA_W'(MFR_ID);
                end
                S_PSRD: begin
                    dq_oe  <= 1'b1;
                    dq_out <= word_lsb ? '0 : DATA_W'(pstat_bit);
                end
                S_RST, S_STBY, S_STBY_PEND, S_ODIS, S_WRITE: begin
                    dq_oe  <= 1'b0;
                    dq_out <= '0;
                end
            endcase
        end
    end

    assign pwr_down = (state_q == S_STBY);

    // Write latch control from the state transition.
    assign wr_hold  = (state_d == S_WRITE);
    assign wr_enter = (state_d == S_WRITE) && (state_q != S_WRITE);
    assign wr_leave = (state_q == S_WRITE) && (state_d != S_WRITE) && (state_d != S_RST);
    assign wr_clear = (state_d == S_RST);

    // R3
    stby_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> !$past(algo_busy));

endmodule

// File: rtl/nor_bus_front.sv
module nor_bus_front
    import nbf_pkg::*;
#(
    parameter int                ADDR_W   = 18,
    parameter int                DATA_W   = 16,
    parameter int                SEC_LSB  = 12,
    parameter logic [DATA_W-1:0] DEV_CODE = 16'h2A70,
    localparam int               SEC_W    = ADDR_W - SEC_LSB,
    localparam int               NSEC     = 1 << SEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              rst_pin_n,
    input  logic              rst_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    input  logic [DATA_W-1:0] array_word,
    input  logic              algo_busy,
    input  logic              prot_wr,
    input  logic [NSEC-1:0]   prot_wdata,
    output logic [NSEC-1:0]   sector_locked,
    output logic              pwr_down,
    output logic              cmd_valid,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data
);

    bus_mode_e mode;
    logic      sel_locked;
    logic      wr_enter;
    logic      wr_hold;
    logic      wr_leave;
    logic      wr_clear;

    nbf_mode_decode u_decode (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .rst_pin_n (rst_pin_n),
        .rst_hv    (rst_hv),
        .a9_hv     (a9_hv),
        .addr6     (addr[6]),
        .addr1     (addr[1]),
        .mode      (mode)
    );

    nbf_protect_map #(.SEC_W(SEC_W)) u_protect (
        .clk           (clk),
        .rst_n         (rst_n),
        .prot_wr       (prot_wr),
        .prot_wdata    (prot_wdata),
        .rst_hv        (rst_hv),
        .sec_idx       (addr[ADDR_W-1:SEC_LSB]),
        .sector_locked (sector_locked),
        .sel_locked    (sel_locked)
    );

    nbf_bus_fsm #(.DATA_W(DATA_W), .DEV_CODE(DEV_CODE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .algo_busy  (algo_busy),
        .word_lsb   (addr[0]),
        .pstat_bit  (sel_locked),
        .array_word (array_word),
        .wr_enter   (wr_enter),
        .wr_hold    (wr_hold),
        .wr_leave   (wr_leave),
        .wr_clear   (wr_clear),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .pwr_down   (pwr_down)
    );

    nbf_write_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wlatch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_enter  (wr_enter),
        .wr_hold   (wr_hold),
        .wr_leave  (wr_leave),
        .wr_clear  (wr_clear),
        .addr      (addr),
        .dq_in     (dq_in),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    // R11
    pinrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_pin_n && !rst_hv) |=> (!dq_oe && !cmd_valid));

    // R1
    drive_needs_enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> $past(!ce_n && !oe_n && we_n));

endmodule

// File: tb/nor_bus_front_tb_top.sv
module nor_bus_front_tb_top;

    localparam logic [15:0] DEV = 16'h2A70;

    logic        clk = 1'b0;
    logic        rst_n, ce_n, oe_n, we_n, rst_pin_n, rst_hv, a9_hv;
    logic [17:0] addr;
    logic [15:0] dq_in, dq_out, array_word, cmd_data;
    logic        dq_oe, algo_busy, prot_wr, pwr_down, cmd_valid;
    logic [63:0] prot_wdata, sector_locked, map;
    logic [17:0] cmd_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    function automatic logic [15:0] arr_fn(input logic [17:0] a);
        return (a[15:0] * 16'd3) ^ 16'hC35A ^ {14'b0, a[17:16]};
    endfunction

    assign array_word = arr_fn(addr);

    nor_bus_front dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rst_pin_n(rst_pin_n), .rst_hv(rst_hv), .a9_hv(a9_hv), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .array_word(array_word),
        .algo_busy(algo_busy), .prot_wr(prot_wr), .prot_wdata(prot_wdata),
        .sector_locked(sector_locked), .pwr_down(pwr_down), .cmd_valid(cmd_valid),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pins(input logic ce, input logic oe, input logic we, input logic [17:0] a);
        ce_n = ce; oe_n = oe; we_n = we; addr = a;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [17:0] a, x2, y2;
        logic [15:0] d2, e2;
        void'($urandom(32'h5EED1234));
        rst_n = 0; ce_n = 1; oe_n = 1; we_n = 1; rst_pin_n = 1; rst_hv = 0; a9_hv = 0;
        addr = '0; dq_in = '0; algo_busy = 0; prot_wr = 0; prot_wdata = '0;
        repeat (3) @(negedge clk);
        chk("R12 dq_oe", dq_oe, 0);
        chk("R12 cmd_valid", cmd_valid, 0);
        chk("R12 pwr_down", pwr_down, 0);
        chk("R12 sector_locked", sector_locked, 0);
        rst_n = 1;
        tick;
        chk("R2 pwr_down", pwr_down, 1);
        chk("R2 dq_oe", dq_oe, 0);

        // R9 load map
        map = {$urandom, $urandom};
        map[5] = 1'b1; map[9] = 1'b0;
        prot_wdata = map; prot_wr = 1;
        tick;
        prot_wr = 0;
        chk("R9 sector_locked", sector_locked, map);

        // R1 reads
        for (int i = 0; i < 8; i++) begin
            a = 18'($urandom);
            pins(0, 0, 1, a);
            tick;
            chk("R1 dq_oe", dq_oe, 1);
            chk("R1 dq_out", dq_out, arr_fn(a));
        end

        // R4 output disable and conflict
        pins(0, 1, 1, 18'h00100);
        tick;
        chk("R4 dq_oe", dq_oe, 0);
        chk("R4 pwr_down", pwr_down, 0);
        pins(0, 0, 0, 18'h00200);
        tick;
        chk("R4 conflict dq_oe", dq_oe, 0);
        pins(1, 1, 1, 18'h00200);
        tick;
        chk("R4 no strobe", cmd_valid, 0);
        chk("R2 standby", pwr_down, 1);

        // R3 deferred standby
        pins(0, 0, 1, 18'h00300);
        tick;
        algo_busy = 1;
        pins(1, 1, 1, 18'h00300);
        for (int i = 0; i < 3; i++) begin
            tick;
            chk("R3 pwr_down held", pwr_down, 0);
            chk("R3 dq_oe", dq_oe, 0);
        end
        algo_busy = 0;
        tick;
        chk("R3 pwr_down after idle", pwr_down, 1);

        // R7 identifier
        a9_hv = 1;
        a = 18'($urandom) & ~18'h00043;
        pins(0, 0, 1, a);
        tick;
        chk("R7 mfr", {dq_oe, dq_out}, {1'b1, 16'h0052});
        pins(0, 0, 1, a | 18'h1);
        tick;
        chk("R7 device", dq_out, DEV);
        pins(0, 0, 1, a | 18'h40);
        tick;
        chk("R7 a6 high reads array", dq_out, arr_fn(a | 18'h40));

        // R8 protect status
        for (int i = 0; i < 10; i++) begin
            logic [5:0] s;
            s = (i == 0) ? 6'd5 : (i == 1) ? 6'd9 : 6'($urandom);
            pins(0, 0, 1, {s, 12'h002});
            tick;
            chk("R8 status bit", dq_out, {15'b0, map[s]});
        end
        pins(0, 0, 1, {6'd5, 12'h003});
        tick;
        chk("R8 offset 3 zero", dq_out, 0);

        // R10 temporary unlock
        rst_hv = 1;
        pins(0, 0, 1, {6'd5, 12'h002});
        tick;
        chk("R10 locks lifted", sector_locked, 0);
        chk("R10 status read", dq_out, 0);
        rst_hv = 0;
        tick;
        chk("R10 map back", sector_locked, map);
        chk("R10 status back", dq_out, 1);
        a9_hv = 0;

        // R5 R6 write enable leading
        pins(1, 1, 0, 18'h01111);
        tick;
        x2 = 18'h2A5A5; d2 = 16'hBEEF;
        pins(0, 1, 0, x2); dq_in = 16'h1234;
        tick;
        chk("R6 no early strobe", cmd_valid, 0);
        pins(0, 1, 0, 18'h03333); dq_in = d2;
        tick;
        pins(1, 1, 0, 18'h03333); dq_in = 16'h7777;
        tick;
        chk("R6 strobe we lead", cmd_valid, 1);
        chk("R5 addr we lead", cmd_addr, x2);
        chk("R6 data we lead", cmd_data, d2);
        tick;
        chk("R6 strobe one cycle", cmd_valid, 0);

        // R5 R6 chip enable leading
        pins(0, 1, 1, 18'h04444);
        tick;
        y2 = 18'h15A5A; e2 = 16'hC0DE;
        pins(0, 1, 0, y2); dq_in = 16'h5555;
        tick;
        pins(0, 1, 0, 18'h06666); dq_in = e2;
        tick;
        pins(0, 1, 1, 18'h06666); dq_in = 16'h8888;
        tick;
        chk("R6 strobe ce lead", cmd_valid, 1);
        chk("R5 addr ce lead", cmd_addr, y2);
        chk("R6 data ce lead", cmd_data, e2);

        // R11 reset pin cuts a write
        pins(0, 1, 0, 18'h09999); dq_in = 16'h4321;
        tick;
        rst_pin_n = 0;
        tick;
        chk("R11 cmd_valid", cmd_valid, 0);
        chk("R11 cmd_addr", cmd_addr, 0);
        chk("R11 cmd_data", cmd_data, 0);
        pins(0, 0, 1, 18'h09999);
        tick;
        chk("R11 dq_oe", dq_oe, 0);
        rst_pin_n = 1;
        pins(1, 1, 1, 18'h09999);
        tick;
        chk("R11 no strobe after release", cmd_valid, 0);

        // Random phase with a bench model
        begin
            bit          wr_prev = 0;
            logic [17:0] lat_a = '0;
            logic [15:0] lat_d = '0;
            for (int i = 0; i < 500; i++) begin
                logic        ce, oe, we, a9, rl, hv, cur_wr, ev, eoe;
                logic [17:0] ra;
                logic [15:0] rd, edat;
                ce = ($urandom % 4) == 0;
                oe = $urandom % 2;
                we = $urandom % 2;
                a9 = ($urandom % 3) == 0;
                ra = 18'($urandom);
                if ($urandom % 2) ra[6] = 1'b0;
                rd = 16'($urandom);
                rl = ($urandom % 16) == 0;
                hv = !rl && (($urandom % 8) == 0);
                pins(ce, oe, we, ra);
                a9_hv = a9; dq_in = rd; rst_pin_n = !rl; rst_hv = hv;
                tick;
                eoe = 0; edat = '0;
                if (!rl && !ce && !oe && we) begin
                    eoe = 1;
                    if (a9 && !ra[6]) begin
                        if (!ra[1]) edat = ra[0] ? DEV : 16'h0052;
                        else edat = ra[0] ? 16'h0 : {15'b0, map[ra[17:12]] & !hv};
                    end else begin
                        edat = arr_fn(ra);
                    end
                end
                cur_wr = !rl && !ce && !we && oe;
                ev = wr_prev && !cur_wr && !rl;
                chk("R1 R7 R8 R11 random dq_oe", dq_oe, eoe);
                if (eoe) chk("R1 R7 R8 R10 random dq_out", dq_out, edat);
                chk("R2 R4 random pwr_down", pwr_down, !rl && ce);
                chk("R6 R11 random cmd_valid", cmd_valid, ev);
                if (ev) begin
                    chk("R5 random cmd_addr", cmd_addr, lat_a);
                    chk("R6 random cmd_data", cmd_data, lat_d);
                end
                if (rl) begin
                    lat_a = '0; lat_d = '0;
                end else if (cur_wr) begin
                    if (!wr_prev) lat_a = ra;
                    lat_d = rd;
                end
                wr_prev = cur_wr;
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule